// File: doc/BRIEF.md
# Indexed Subaddress Buffer Controller

This block performs the end-of-message work for one receive subaddress or mode code descriptor of a MIL-STD-1553 remote terminal that runs in index mode. When the protocol engine reports that a receive message has completed, the block reports where the message information word and its data go. It marks broadcast messages in the information word when needed. It advances the main data pointer, counts the index register down and queues interrupt requests in a small log that the host drains.

A global routing bit picks one of two broadcast schemes. With the bit set, broadcast messages land in a dedicated broadcast buffer and leave the index and the main pointer alone, so the host must empty that buffer before the next broadcast arrives. With the bit clear, broadcast and addressed messages share the main buffer and count alike. Broadcast messages are then tagged in their information word, so the host can separate them later.

An index of zero is single-message mode: the same buffer location is reused. A loaded count of N gives N-message indexing. The pointer stops advancing once the count is spent, so an unserviced buffer is never overrun.

Top module: `ixpp_top`

## Requirements
- R1: After reset the index and pointer read 0, the log is empty (log_valid_o low, log_head_o 0) and log_ovf_o is low.
- R2: A descriptor load sets index_o and ptr_a_o from load_index_i and load_ptr_i on the next clock edge. It takes priority over a message completing in the same cycle, which then changes neither.
- R3: With sep_bcast_i set, a completing broadcast message drives store_addr_o to bbuf_base_i and store_bbuf_o high, and leaves index_o and ptr_a_o unchanged.
- R4: Any other completing message drives store_addr_o to ptr_a_o with store_bbuf_o low. miw_bcast_o is high exactly when the message is broadcast and sep_bcast_i is clear.
- R5: A message stored in the main buffer while the index is nonzero decrements the index by one and advances the pointer by one plus msg_wcnt_i, modulo 2^ADDR_W.
- R6: A message stored in the main buffer while the index is zero leaves both index and pointer unchanged.
- R7: The index-zero interrupt is raised when a main-buffer message takes the index from one to zero and ien_ixeqz_i is set.
- R8: The broadcast interrupt is raised for a broadcast message, in either mode, only when both ctl_ibr_i and ien_ibr_i are set.
- R9: The any-message interrupt is raised on every completed message when both ctl_iwa_i and ien_iwa_i are set.
- R10: A message that raises at least one interrupt pushes one log entry: bits [7:3] desc_id_i, bit 2 broadcast, bit 1 index-zero, bit 0 any-message. Entries leave in arrival order. log_entry_o shows the entry at slot log_head_o, and log_pop_i removes it.
- R11: The log holds 4 entries. log_ovf_o sets when a push fills the log. A push into a full log without a pop is dropped. log_ovf_o clears when a pop empties the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sep_bcast_i | input | 1 | Global bit: broadcast to separate buffer |
| ien_ibr_i | input | 1 | Interrupt enable, broadcast received |
| ien_ixeqz_i | input | 1 | Interrupt enable, index reached zero |
| ien_iwa_i | input | 1 | Interrupt enable, any message |
| ctl_ibr_i | input | 1 | Descriptor control, broadcast interrupt |
| ctl_iwa_i | input | 1 | Descriptor control, any-message interrupt |
| desc_id_i | input | 5 | Subaddress or mode code identity for the log |
| bbuf_base_i | input | 16 | Broadcast buffer address |
| desc_load_i | input | 1 | Load index and pointer |
| load_index_i | input | 8 | Index value to load |
| load_ptr_i | input | 16 | Pointer value to load |
| msg_done_i | input | 1 | Receive message complete, one-cycle pulse |
| msg_bcast_i | input | 1 | Completed message was broadcast |
| msg_wcnt_i | input | 6 | Data words received, 1 to 32 |
| log_pop_i | input | 1 | Host removes head log entry |
| store_addr_o | output | 16 | Address for information word and data |
| store_bbuf_o | output | 1 | Message goes to the broadcast buffer |
| miw_bcast_o | output | 1 | Broadcast tag for the stored information word |
| index_o | output | 8 | Index register |
| ptr_a_o | output | 16 | Main data pointer |
| log_valid_o | output | 1 | Log not empty |
| log_entry_o | output | 8 | Entry at the log head |
| log_head_o | output | 2 | Log head slot |
| log_ovf_o | output | 1 | Log filled |

## Verification
The assertions watch, on every cycle, the fixed relations. Routed broadcasts leave index and pointer frozen, a zero index stays zero, the broadcast interrupt never fires without a broadcast, and the log never grows past full or drops an entry when it has room. Only the bench's sweeps show that the arithmetic holds: pointer advance by word count, the one-to-zero interrupt in the right message, the entry contents, FIFO order, and the set and clear points of the overflow flag. The bench shows this for both routing modes, for starting counts 0 to 3, and for every combination of enable bits.

// File: rtl/ixpp_pkg.sv
package ixpp_pkg;
  localparam int ID_W  = 5;
  localparam int IRQ_N = 3;

  typedef struct packed {
    logic ibr;
    logic ixeqz;
    logic iwa;
  } irq_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    irq_t            irq;
  } log_ent_t;
endpackage

// File: rtl/ixpp_route.sv
module ixpp_route
  import ixpp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int WC_W   = 6
) (
  input  logic              msg_done_i,
  input  logic              msg_bcast_i,
  input  logic [WC_W-1:0]   msg_wcnt_i,
  input  logic              sep_bcast_i,
  input  logic              ien_ibr_i,
  input  logic              ien_ixeqz_i,
  input  logic              ien_iwa_i,
  input  logic              ctl_ibr_i,
  input  logic              ctl_iwa_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [ADDR_W-1:0] ptr_a_i,
  input  logic [ADDR_W-1:0] bbuf_base_i,
  output logic [ADDR_W-1:0] store_addr_o,
  output logic              store_bbuf_o,
  output logic              miw_bcast_o,
  output logic              step_o,
  output logic [ADDR_W-1:0] ptr_next_o,
  output irq_t              irq_o,
  output logic              push_o
);
  logic to_bbuf, counted, idx_nz, idx_one;

  assign to_bbuf = msg_bcast_i & sep_bcast_i;
  assign counted = ~to_bbuf;
  assign idx_nz  = |index_i;
  assign idx_one = (index_i == IDX_W'(1));

  assign store_bbuf_o = to_bbuf;
  assign store_addr_o = to_bbuf ? bbuf_base_i : ptr_a_i;
  assign miw_bcast_o  = msg_bcast_i & ~sep_bcast_i;

  // only main-buffer messages consume index slots
  assign step_o     = msg_done_i & counted & idx_nz;
  assign ptr_next_o = ptr_a_i + ADDR_W'(msg_wcnt_i) + ADDR_W'(1);

  always_comb begin
    irq_o       = '0;
    irq_o.ibr   = msg_done_i & msg_bcast_i & ctl_ibr_i & ien_ibr_i;
    irq_o.ixeqz = msg_done_i & counted & idx_one & ien_ixeqz_i;
    irq_o.iwa   = msg_done_i & ctl_iwa_i & ien_iwa_i;
  end

  assign push_o = |irq_o;
endmodule

// File: rtl/ixpp_state.sv
module ixpp_state #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_index_i,
  input  logic [ADDR_W-1:0] load_ptr_i,
  input  logic              msg_done_i,
  input  logic              step_i,
  input  logic              to_bbuf_i,
  input  logic [ADDR_W-1:0] ptr_next_i,
  output logic [IDX_W-1:0]  index_o,
  output logic [ADDR_W-1:0] ptr_a_o
);
  logic [IDX_W-1:0]  index_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ptr_q   <= '0;
    end else if (load_i) begin
      index_q <= load_index_i;
      ptr_q   <= load_ptr_i;
    end else if (step_i) begin
      index_q <= index_q - IDX_W'(1);
      ptr_q   <= ptr_next_i;
    end
  end

  assign index_o = index_q;
  assign ptr_a_o = ptr_q;

  a_r3_bbuf_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_done_i && to_bbuf_i && !load_i) |=> ($stable(index_q) && $stable(ptr_q)));

  a_r6_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_done_i && index_q == '0 && !load_i) |=> (index_q == '0 && $stable(ptr_q)));

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (index_q == $past(load_index_i) && ptr_q == $past(load_ptr_i)));
endmodule

// File: rtl/ixpp_log.sv
module ixpp_log #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [W-1:0]  head_data_o,
  output logic [PW-1:0] head_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q;
  logic          full, do_pop, do_push;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i & (cnt_q != '0);
  assign do_push = push_i & (~full | do_pop);

  always_comb begin
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_push && cnt_d == CW'(DEPTH)) ovf_q <= 1'b1;
      else if (cnt_d == '0)               ovf_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (do_push && wr_q == PW'(g))     mem_q[g] <= data_i;
    end
  end

  assign valid_o     = (cnt_q != '0);
  assign head_data_o = mem_q[rd_q];
  assign head_o      = rd_q;
  assign ovf_o       = ovf_q;

  a_r11_never_exceeds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  a_r11_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_i) |=> full && $stable(wr_q));

  a_r10_push_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full && !pop_i) |=> cnt_q == $past(cnt_q) + CW'(1));

  a_r11_ovf_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> full);
endmodule

// File: rtl/ixpp_top.sv
module ixpp_top
  import ixpp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 8,
  parameter int WC_W      = 6,
  parameter int LOG_DEPTH = 4,
  localparam int LP_W     = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int ENT_W    = ID_W + IRQ_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sep_bcast_i,
  input  logic              ien_ibr_i,
  input  logic              ien_ixeqz_i,
  input  logic              ien_iwa_i,
  input  logic              ctl_ibr_i,
  input  logic              ctl_iwa_i,
  input  logic [ID_W-1:0]   desc_id_i,
  input  logic [ADDR_W-1:0] bbuf_base_i,
  input  logic              desc_load_i,
  input  logic [IDX_W-1:0]  load_index_i,
  input  logic [ADDR_W-1:0] load_ptr_i,
  input  logic              msg_done_i,
  input  logic              msg_bcast_i,
  input  logic [WC_W-1:0]   msg_wcnt_i,
  input  logic              log_pop_i,
  output logic [ADDR_W-1:0] store_addr_o,
  output logic              store_bbuf_o,
  output logic              miw_bcast_o,
  output logic [IDX_W-1:0]  index_o,
  output logic [ADDR_W-1:0] ptr_a_o,
  output logic              log_valid_o,
  output logic [ENT_W-1:0]  log_entry_o,
  output logic [LP_W-1:0]   log_head_o,
  output logic              log_ovf_o
);
  logic [IDX_W-1:0]  index;
  logic [ADDR_W-1:0] ptr_a, ptr_next;
  logic              step, push, to_bbuf;
  irq_t              irq;
  log_ent_t          ent;

  ixpp_route #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WC_W(WC_W)) i_route (
    .msg_done_i   (msg_done_i),
    .msg_bcast_i  (msg_bcast_i),
    .msg_wcnt_i   (msg_wcnt_i),
    .sep_bcast_i  (sep_bcast_i),
    .ien_ibr_i    (ien_ibr_i),
    .ien_ixeqz_i  (ien_ixeqz_i),
    .ien_iwa_i    (ien_iwa_i),
    .ctl_ibr_i    (ctl_ibr_i),
    .ctl_iwa_i    (ctl_iwa_i),
    .index_i      (index),
    .ptr_a_i      (ptr_a),
    .bbuf_base_i  (bbuf_base_i),
    .store_addr_o (store_addr_o),
    .store_bbuf_o (to_bbuf),
    .miw_bcast_o  (miw_bcast_o),
    .step_o       (step),
    .ptr_next_o   (ptr_next),
    .irq_o        (irq),
    .push_o       (push)
  );

  // a load in the same cycle cancels the message's bookkeeping
  ixpp_state #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (desc_load_i),
    .load_index_i (load_index_i),
    .load_ptr_i   (load_ptr_i),
    .msg_done_i   (msg_done_i),
    .step_i       (step),
    .to_bbuf_i    (to_bbuf),
    .ptr_next_i   (ptr_next),
    .index_o      (index),
    .ptr_a_o      (ptr_a)
  );

  assign ent.id  = desc_id_i;
  assign ent.irq = irq;

  ixpp_log #(.DEPTH(LOG_DEPTH), .W(ENT_W)) i_log (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .data_i      (ent),
    .pop_i       (log_pop_i),
    .valid_o     (log_valid_o),
    .head_data_o (log_entry_o),
    .head_o      (log_head_o),
    .ovf_o       (log_ovf_o)
  );

  assign store_bbuf_o = to_bbuf;
  assign index_o      = index;
  assign ptr_a_o      = ptr_a;

  a_r4_tag_not_in_bbuf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_bbuf |-> !miw_bcast_o);

  a_r8_ibr_needs_bcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq.ibr |-> (msg_done_i && msg_bcast_i));

  a_r7_ixeqz_last_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq.ixeqz && !desc_load_i) |=> index == '0);

  a_r5_step_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !desc_load_i) |=> index == $past(index) - IDX_W'(1));
endmodule

// File: tb/test_ixpp_top.sv
module test_ixpp_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sep, ien_ibr, ien_ixeqz, ien_iwa, ctl_ibr, ctl_iwa;
  logic [4:0]  id;
  logic [15:0] bbase, lptr;
  logic        load, done, bc, pop;
  logic [7:0]  lidx;
  logic [5:0]  wc;
  logic [15:0] st_addr, ptr;
  logic        st_bb, miwb, lvalid, lovf;
  logic [7:0]  idx, lent;
  logic [1:0]  lhead;

  ixpp_top i_ixpp_top (
    .clk_i(clk), .rst_ni(rst_n), .sep_bcast_i(sep), .ien_ibr_i(ien_ibr),
    .ien_ixeqz_i(ien_ixeqz), .ien_iwa_i(ien_iwa), .ctl_ibr_i(ctl_ibr),
    .ctl_iwa_i(ctl_iwa), .desc_id_i(id), .bbuf_base_i(bbase),
    .desc_load_i(load), .load_index_i(lidx), .load_ptr_i(lptr),
    .msg_done_i(done), .msg_bcast_i(bc), .msg_wcnt_i(wc), .log_pop_i(pop),
    .store_addr_o(st_addr), .store_bbuf_o(st_bb), .miw_bcast_o(miwb),
    .index_o(idx), .ptr_a_o(ptr), .log_valid_o(lvalid), .log_entry_o(lent),
    .log_head_o(lhead), .log_ovf_o(lovf)
  );

  int checks = 0, errors = 0;
  // model
  int m_idx, m_ptr, m_cnt, m_head, m_tail;
  bit m_ovf;
  int q [4];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic log_push(input int e);
    if (m_cnt < 4) begin
      q[m_tail] = e;
      m_tail = (m_tail + 1) % 4;
      m_cnt++;
      if (m_cnt == 4) m_ovf = 1;
    end
  endtask

  task automatic send(input bit b, input int w);
    bit counted, ibr, ixz, iwa;
    int e;
    @(negedge clk);
    done = 1; bc = b; wc = 6'(w);
    #1;
    if (b && sep) begin
      chk("R3 addr", st_addr, bbase);
      chk("R3 bbuf", st_bb, 1);
    end else begin
      chk("R4 addr", st_addr, m_ptr);
      chk("R4 bbuf", st_bb, 0);
    end
    chk("R4 miw tag", miwb, b && !sep);
    counted = !(b && sep);
    ibr = b && ctl_ibr && ien_ibr;
    ixz = counted && m_idx == 1 && ien_ixeqz;
    iwa = ctl_iwa && ien_iwa;
    e = (int'(id) << 3) | (int'(ibr) << 2) | (int'(ixz) << 1) | int'(iwa);
    if (ibr || ixz || iwa) log_push(e);
    if (counted && m_idx != 0) begin
      m_idx--;
      m_ptr = (m_ptr + 1 + w) % 65536;
    end
    @(negedge clk);
    done = 0; bc = 0;
    if (b && sep) begin
      chk("R3 index frozen", idx, m_idx);
      chk("R3 ptr frozen", ptr, m_ptr);
    end else begin
      chk("R5 R6 index", idx, m_idx);
      chk("R5 R6 ptr", ptr, m_ptr);
    end
  endtask

  task automatic drain;
    chk("R11 ovf before drain", lovf, m_ovf);
    while (m_cnt > 0) begin
      chk("R10 valid", lvalid, 1);
      chk("R10 head", lhead, m_head);
      chk("R7 R8 R9 R10 entry", lent, q[m_head]);
      pop = 1;
      @(negedge clk);
      pop = 0;
      m_head = (m_head + 1) % 4;
      m_cnt--;
      if (m_cnt == 0) m_ovf = 0;
      chk("R11 ovf", lovf, m_ovf);
    end
    chk("R10 empty", lvalid, 0);
  endtask

  task automatic do_load(input int i, input int p);
    @(negedge clk);
    load = 1; lidx = 8'(i); lptr = 16'(p);
    @(negedge clk);
    load = 0;
    m_idx = i; m_ptr = p;
    chk("R2 load index", idx, i);
    chk("R2 load ptr", ptr, p);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sep = 0; ien_ibr = 0; ien_ixeqz = 0; ien_iwa = 0; ctl_ibr = 0; ctl_iwa = 0;
    id = 0; bbase = 16'h8000; load = 0; lidx = 0; lptr = 0;
    done = 0; bc = 0; wc = 1; pop = 0;
    m_idx = 0; m_ptr = 0; m_cnt = 0; m_head = 0; m_tail = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 index", idx, 0);
    chk("R1 ptr", ptr, 0);
    chk("R1 valid", lvalid, 0);
    chk("R1 head", lhead, 0);
    chk("R1 ovf", lovf, 0);

    // R2: load beats a simultaneous message
    @(negedge clk);
    load = 1; lidx = 8'd3; lptr = 16'h0100; done = 1; bc = 0; wc = 6'd5;
    ien_iwa = 0;
    @(negedge clk);
    load = 0; done = 0;
    chk("R2 load priority index", idx, 3);
    chk("R2 load priority ptr", ptr, 16'h0100);

    for (int s = 0; s < 2; s++) begin
      for (int i0 = 0; i0 < 4; i0++) begin
        for (int en = 0; en < 32; en++) begin
          sep = s[0];
          ctl_ibr = en[0]; ien_ibr = en[1]; ien_ixeqz = en[2];
          ctl_iwa = en[3]; ien_iwa = en[4];
          id = 5'(en + i0);
          bbase = 16'(16'h8000 + en * 64);
          do_load(i0, (en * 997 + i0 * 13 + 65500) % 65536);
          for (int k = 0; k < 6; k++)
            send(((en + k) % 3) == 0, ((k * 7 + en) % 32) + 1);
          drain();
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule